// File: doc/BRIEF.md
# Per-Channel Offset Trim Calibrator

This block levels the DC output of a time-multiplexed recording array. Each scanned channel gets its own bias-current trim code. After a start request the block visits the channels one after another, from channel 0 upward, while the scan is held on the channel under test. For each channel it raises a current-DAC trim code from zero, one step at a time. It waits a programmable number of clocks after each step so that the analog path can settle. The search stops at the first code where the digitized output is no longer below the target level, and that code is written into a per-channel table.

Once calibration is over, the block replays the table. Every clock it looks up the code for the channel index that the scan controller is about to enable, and it registers that code so the DAC input is ready one clock early. The below-target decision comes from one of two sources. It is either an external comparator flag or an unsigned compare of a digitized sample against a target code. A channel that is still below target at full scale is stored at full scale and raises a sticky failure flag.

Top module: `offset_trim_cal`

## Requirements
- R1: After reset, trim_o, busy_o, done_o, fail_o and cal_ch_o are all 0, and every table entry reads back as 0.
- R2: A start_i seen at a clock edge while idle makes busy_o 1, done_o 0, fail_o 0, cal_ch_o 0 and trim_o 0 after that edge.
- R3: With cmp_src_i = 1 the below-target decision is below_i, and sample_i and target_i are ignored. With cmp_src_i = 0 the decision is sample_i < target_i (unsigned), and below_i is ignored.
- R4: While busy, trim_o shows the code under test. It starts at 0 for each channel and only ever rises by exactly 1 within a channel.
- R5: Each code is held for settle_i + 1 clocks, and the decision is taken at the last of those clocks. A channel whose search ends at code k therefore keeps busy_o high for (k + 1) x (settle_i + 1) clocks.
- R6: When the decision at code k is not below, code k is stored for that channel and the search moves to the next channel starting at code 0.
- R7: When the decision at full scale (2000) is still below, 2000 is stored and fail_o goes to 1. fail_o stays 1 until the next start. A decision that is not below at exactly 2000 stores 2000 without a failure.
- R8: Channels are calibrated in ascending order 0 to 255, and cal_ch_o shows the channel under test.
- R9: At the edge where the last channel is stored, busy_o falls and done_o rises. done_o and busy_o are never both 1, and done_o stays 1 until the next start.
- R10: While idle, trim_o after a clock edge equals the stored code of the channel index that scan_ch_i held at that edge.
- R11: A start_i while busy has no effect: the search order, codes and total busy duration are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to calibrate all channels |
| cmp_src_i | input | 1 | Decision source: 1 = below_i, 0 = sample_i < target_i |
| below_i | input | 1 | External below-target flag |
| sample_i | input | 12 | Digitized output sample |
| target_i | input | 12 | Target level code |
| settle_i | input | 8 | Extra clocks each code is held before the decision |
| scan_ch_i | input | 8 | Channel index that the scan enables next |
| trim_o | output | 11 | Trim code to the bias current DAC |
| cal_ch_o | output | 8 | Channel under calibration |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | All channels calibrated |
| fail_o | output | 1 | Some channel hit full scale still below target |

## Verification
If the step counter or the settle timer is wrong, the error shows up as a changed busy duration, which the bench predicts to the exact clock from the threshold it gives each channel. If the channel counter is wrong, cal_ch_o skips a channel or trim_o fails to restart at 0, and this is seen within one clock of the channel change. If a table entry is wrong, it stays hidden until replay. It then shows on trim_o exactly one clock after the bench presents that channel index. Choosing the wrong decision source, or breaking the full-scale path, makes the searches end at the wrong codes, which also moves the busy duration.

// File: rtl/otc_pkg.sv
package otc_pkg;

  localparam int CH_N_DEF     = 256;
  localparam int CODE_W_DEF   = 11;
  localparam int CODE_MAX_DEF = 2000;
  localparam int SMP_W_DEF    = 12;
  localparam int SET_W_DEF    = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } cal_state_e;

  // Decision: is the channel output still under the target level?
  function automatic logic below_target(input logic        use_flag,
                                        input logic        flag,
                                        input logic [31:0] sample,
                                        input logic [31:0] target);
    return use_flag ? flag : (sample < target);
  endfunction

  // Code has reached the top of the DAC range
  function automatic logic at_ceiling(input logic [31:0] code,
                                      input logic [31:0] cmax);
    return code >= cmax;
  endfunction

endpackage

// File: rtl/otc_settle_timer.sv
module otc_settle_timer #(
  parameter int SET_W = otc_pkg::SET_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [SET_W-1:0] settle_i,
  output logic             expire_o
);

  logic [SET_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (reload_i) begin
      cnt_q <= settle_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - SET_W'(1);
    end
  end

  assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/otc_trim_table.sv
module otc_trim_table #(
  parameter int CH_N   = otc_pkg::CH_N_DEF,
  parameter int CODE_W = otc_pkg::CODE_W_DEF,
  localparam int CH_W  = $clog2(CH_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]   rd_addr_i,
  output logic [CODE_W-1:0] rd_data_o
);

  logic [CODE_W-1:0] mem_q [CH_N];
  logic [CODE_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < CH_N; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // registered lookup: valid one clock ahead of the channel enable
  always_ff @(posedge clk_i) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/otc_search_fsm.sv
module otc_search_fsm #(
  parameter int CH_N     = otc_pkg::CH_N_DEF,
  parameter int CODE_W   = otc_pkg::CODE_W_DEF,
  parameter int CODE_MAX = otc_pkg::CODE_MAX_DEF,
  localparam int CH_W    = $clog2(CH_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              below_i,
  input  logic              expire_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              reload_o,
  output logic              wr_en_o,
  output logic [CH_W-1:0]   wr_addr_o,
  output logic [CODE_W-1:0] wr_data_o,
  output logic              step_ev_o,
  output logic              lock_ev_o
);
  import otc_pkg::*;

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(CH_N - 1);

  cal_state_e        state_q;
  logic [CODE_W-1:0] code_q;
  logic [CH_W-1:0]   ch_q;
  logic              done_q, fail_q;

  logic busy, start_ev, top_hit, step_ev, lock_ev, fail_ev, last_ch;

  assign busy     = (state_q == ST_RAMP);
  assign start_ev = start_i && !busy;
  assign top_hit  = at_ceiling(32'(code_q), 32'(CODE_MAX));
  assign step_ev  = busy && expire_i && below_i && !top_hit;
  assign lock_ev  = busy && expire_i && !(below_i && !top_hit);
  assign fail_ev  = lock_ev && below_i;
  assign last_ch  = (ch_q == LAST_CH);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      ch_q    <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else if (start_ev) begin
      state_q <= ST_RAMP;
      code_q  <= '0;
      ch_q    <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else if (step_ev) begin
      code_q <= code_q + CODE_W'(1);
    end else if (lock_ev) begin
      if (fail_ev) fail_q <= 1'b1;
      if (last_ch) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else begin
        ch_q   <= ch_q + CH_W'(1);
        code_q <= '0;
      end
    end
  end

  assign busy_o    = busy;
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign code_o    = code_q;
  assign ch_o      = ch_q;
  assign reload_o  = start_ev || step_ev || (lock_ev && !last_ch);
  assign wr_en_o   = lock_ev;
  assign wr_addr_o = ch_q;
  assign wr_data_o = code_q;
  assign step_ev_o = step_ev;
  assign lock_ev_o = lock_ev;

  // R4
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_ev |=> (code_q == $past(code_q) + CODE_W'(1)) && (ch_q == $past(ch_q)));

  // R6
  lock_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_ev && !last_ch) |=> (code_q == '0) && (ch_q == $past(ch_q) + CH_W'(1)));

  // R11
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i && !step_ev && !lock_ev) |=> busy && $stable(ch_q) && $stable(code_q));

  // R9
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $fell(state_q == ST_RAMP));

endmodule

// File: rtl/offset_trim_cal.sv
module offset_trim_cal #(
  parameter int CH_N     = otc_pkg::CH_N_DEF,
  parameter int CODE_W   = otc_pkg::CODE_W_DEF,
  parameter int CODE_MAX = otc_pkg::CODE_MAX_DEF,
  parameter int SMP_W    = otc_pkg::SMP_W_DEF,
  parameter int SET_W    = otc_pkg::SET_W_DEF,
  localparam int CH_W    = $clog2(CH_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_src_i,
  input  logic              below_i,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic [SMP_W-1:0]  target_i,
  input  logic [SET_W-1:0]  settle_i,
  input  logic [CH_W-1:0]   scan_ch_i,
  output logic [CODE_W-1:0] trim_o,
  output logic [CH_W-1:0]   cal_ch_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);
  import otc_pkg::*;

  logic              below_sel, expire, reload;
  logic              busy, done, fail, step_ev, lock_ev;
  logic              wr_en;
  logic [CH_W-1:0]   wr_addr, ch;
  logic [CODE_W-1:0] wr_data, code, replay;

  assign below_sel = below_target(cmp_src_i, below_i, 32'(sample_i), 32'(target_i));

  otc_settle_timer #(.SET_W(SET_W)) timer_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .settle_i (settle_i),
    .expire_o (expire)
  );

  otc_search_fsm #(.CH_N(CH_N), .CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) fsm_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .below_i   (below_sel),
    .expire_i  (expire),
    .busy_o    (busy),
    .done_o    (done),
    .fail_o    (fail),
    .code_o    (code),
    .ch_o      (ch),
    .reload_o  (reload),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .step_ev_o (step_ev),
    .lock_ev_o (lock_ev)
  );

  otc_trim_table #(.CH_N(CH_N), .CODE_W(CODE_W)) table_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (scan_ch_i),
    .rd_data_o (replay)
  );

  assign trim_o   = busy ? code : replay;
  assign cal_ch_o = ch;
  assign busy_o   = busy;
  assign done_o   = done;
  assign fail_o   = fail;

  // R9
  done_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done && busy));

  // R7
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (code <= CODE_W'(CODE_MAX)));

  // R5
  settle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !$past(expire)) |-> ($stable(code) && $stable(ch)));

  // R6
  lock_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_ev |-> (wr_en && !step_ev));

endmodule

// File: tb/offset_trim_cal_tb.sv
module offset_trim_cal_tb_top;

  localparam int NCH  = 256;
  localparam int CMAX = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cmp_src = 1'b1, below = 1'b0;
  logic [11:0] sample = '0, target = '0;
  logic [7:0]  settle = '0, scan_ch = '0;
  logic [10:0] trim;
  logic [7:0]  cal_ch;
  logic        busy, done, fail;

  int n_total = 0, n_pass = 0;
  int thr [NCH];
  int off [NCH];
  int exp_code [NCH];

  always #2 clk = ~clk;

  offset_trim_cal dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_src_i(cmp_src),
    .below_i(below), .sample_i(sample), .target_i(target), .settle_i(settle),
    .scan_ch_i(scan_ch), .trim_o(trim), .cal_ch_o(cal_ch), .busy_o(busy),
    .done_o(done), .fail_o(fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
  endtask

  // expected lock code for one channel, restated from the requirements
  function automatic int lock_code(input bit flagmode, input int ch, input int tgt);
    int k;
    if (flagmode) k = thr[ch];
    else          k = (tgt > off[ch]) ? tgt - off[ch] : 0;
    return (k > CMAX) ? CMAX : k;
  endfunction

  function automatic bit will_fail(input bit flagmode, input int ch, input int tgt);
    if (flagmode) return thr[ch] > CMAX;
    return (tgt - off[ch]) > CMAX;
  endfunction

  task automatic run_cal(input bit flagmode, input int s, input int tgt, input bit inject);
    int exp_cycles = 0, cyc = 0, prev_ch = 0, prev_code = 0;
    int ramp_bad = 0, order_bad = 0;
    bit exp_fail = 0;
    for (int c = 0; c < NCH; c++) begin
      exp_code[c] = lock_code(flagmode, c, tgt);
      exp_cycles += (exp_code[c] + 1) * (s + 1);
      if (will_fail(flagmode, c, tgt)) exp_fail = 1;
    end
    cmp_src = flagmode;
    settle  = 8'(s);
    target  = 12'(tgt);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 state right after the start edge
    chk(busy == 1'b1 && done == 1'b0, "R2 busy/done after start", {busy, done}, 2);
    chk(cal_ch == 0 && trim == 0 && fail == 1'b0, "R2 channel/code/fail cleared", int'(trim), 0);
    while (busy && cyc < 60000) begin
      // plant model (R3): the unused source is driven to the misleading value
      if (flagmode) begin
        below  = (int'(trim) < thr[cal_ch]);
        sample = 12'hFFF;
      end else begin
        below  = 1'b1;
        sample = 12'(int'(trim) + off[cal_ch]);
      end
      if (int'(cal_ch) == prev_ch) begin
        if (int'(trim) != prev_code && int'(trim) != prev_code + 1) ramp_bad++;
      end else if (int'(cal_ch) != prev_ch + 1 || trim != 0) begin
        order_bad++;
      end
      prev_ch   = int'(cal_ch);
      prev_code = int'(trim);
      start = (inject && (cyc == 37 || cyc == 400)) ? 1'b1 : 1'b0;  // R11 stimulus
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(ramp_bad == 0, "R4 code ramps by one per step", ramp_bad, 0);
    chk(order_bad == 0 && prev_ch == NCH - 1, "R8 ascending channel order", prev_ch, NCH - 1);
    chk(cyc == exp_cycles, inject ? "R11 R5 busy duration with start while busy" :
                                    "R5 busy duration", cyc, exp_cycles);
    chk(done == 1'b1 && busy == 1'b0, "R9 done after last channel", {busy, done}, 1);
    chk(fail == exp_fail, "R7 fail flag", int'(fail), int'(exp_fail));
  endtask

  task automatic replay_chk(input int n);
    int bad = 0, first_bad = -1, act = 0, ev = 0;
    for (int i = 0; i < n; i++) begin
      int c;
      c = (i < 4) ? ((i == 0) ? 0 : (i == 1) ? 7 : (i == 2) ? 9 : NCH - 1) : int'($urandom_range(NCH - 1));
      scan_ch = 8'(c);
      @(negedge clk);
      if (int'(trim) != exp_code[c]) begin
        bad++;
        if (first_bad < 0) begin first_bad = c; act = int'(trim); ev = exp_code[c]; end
      end
    end
    chk(bad == 0, "R10 R6 replayed table codes", act, ev);
    chk(done == 1'b1, "R9 done holds while idle", int'(done), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    n_total++;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(trim == 0 && busy == 0 && done == 0 && fail == 0 && cal_ch == 0,
        "R1 reset outputs", int'(trim), 0);
    scan_ch = 8'd200;
    @(negedge clk);
    chk(trim == 0, "R1 table empty after reset", int'(trim), 0);

    // run 1: flag decision, settle 1, zero lock, exact full scale, one failure
    for (int c = 0; c < NCH; c++) thr[c] = int'($urandom_range(30));
    thr[0] = 0;
    thr[7] = 2600;
    thr[9] = CMAX;
    run_cal(1'b1, 1, 0, 1'b0);
    chk(exp_code[7] == CMAX && exp_code[9] == CMAX, "R7 full-scale expectations", exp_code[7], CMAX);
    replay_chk(40);

    // run 2: sample decision against target, settle 0
    for (int c = 0; c < NCH; c++) off[c] = 1170 + int'($urandom_range(45));
    off[3] = 1300;
    run_cal(1'b0, 0, 1200, 1'b0);
    replay_chk(40);

    // run 3: flag decision, settle 3, start pulses while busy
    for (int c = 0; c < NCH; c++) thr[c] = int'($urandom_range(8));
    run_cal(1'b1, 3, 0, 1'b1);
    replay_chk(20);

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

endmodule